// File: doc/BRIEF.md
# Five-Input Table Logic Cell with Two Registers

This block is one coarse-grain configurable logic cell. A 32-entry single-bit table is read with an address built from the five logic inputs and the two register outputs, giving two combinational results F and G. Three table modes are offered: the whole table as one five-variable function (F and G equal), the table split into two sixteen-entry halves with their own four-variable functions, or the two halves with a chosen variable picking between them. Two registers share a clock, a clock enable and an asynchronous direct clear. Each register loads F or G. Each of the two outputs shows F, G or either register.

The cell is set up through a parallel write port. While the write enable is high, each clock edge stores one 16-bit word into the cell's setup state, the registers keep their values and both outputs are held low. Every function has the same combinational path, one table read after the address selection.

Top module: `lut5_logic_cell`

## Requirements
- R1: In single mode (mode code 0, and the unused code 3 acts the same), F and G both equal table entry `{v(msel), v(fsel3), v(fsel2), v(fsel1), v(fsel0)}`, where v(s) is the variable picked by select code s and fsel0 is the least significant address bit.
- R2: With only table entry 31 set, A..E chosen as fsel0..fsel3 and msel (A in the LSB), and single mode, F is 1 only for inputs 11111 and 0 for the other 31 patterns.
- R3: In split mode (mode code 1), F equals entry `{0, v(fsel3..fsel0)}` and G equals entry `{1, v(gsel3..gsel0)}`.
- R4: In mux mode (mode code 2), F and G both equal entry `{1, v(gsel3..gsel0)}` when v(msel) is 1, and entry `{0, v(fsel3..fsel0)}` when it is 0.
- R5: Select codes 0 to 4 pick inputs A to E (lin bits 0 to 4), code 5 picks register QX, code 6 picks register QY and code 7 gives constant 0.
- R6: Output steering codes for X and Y are 0 = F, 1 = G, 2 = QX, 3 = QY, set for each output on its own.
- R7: On a rising clock edge with ce high and cfg_en low, QX loads F (dsel_x = 0) or G (dsel_x = 1), and QY loads F or G by dsel_y; with ce low both registers keep their values.
- R8: rd high clears QX and QY at once, without waiting for a clock edge.
- R9: While cfg_en is high, X and Y are 0 and both registers keep their values whatever ce is.
- R10: Asserting rst_n low clears the table, all select and steering fields, the mode and both registers, so X and Y read 0 once the reset has been released.
- R11: Setup words: address 0 gives table entries 15..0, address 1 gives entries 31..16, address 2 gives fsel0..fsel3 in 3-bit fields from bit 0 and msel in bits 14:12, address 3 gives gsel0..gsel3 in 3-bit fields from bit 0, address 4 gives mode in bits 1:0, X steering in 3:2, Y steering in 5:4, dsel_x in bit 6 and dsel_y in bit 7; writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| lin | input | 5 | Logic inputs A (bit 0) to E (bit 4) |
| rd | input | 1 | Asynchronous direct clear of both registers, active high |
| ce | input | 1 | Register clock enable |
| cfg_en | input | 1 | Setup write enable |
| cfg_addr | input | 3 | Setup word address |
| cfg_data | input | 16 | Setup word data |
| x | output | 1 | Steered output X |
| y | output | 1 | Steered output Y |

## Verification
A scrambled table is read through reversed F and G select orders under all four mode codes, with input patterns chosen so that the upper and lower halves differ, F and G differ, and the selected mux variable takes both values. The five-input AND table is then swept over all 32 patterns to show that exactly one address reads as 1. Register feedback through the QX and QY select codes, the constant code, the load of F against G, the hold with ce low, the asynchronous clear seen before any edge, and the blocking during setup each use register contents that differ from what a wrong path would produce.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
  localparam int HALF_AW   = 4;
  localparam int TBL_AW    = HALF_AW + 1;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int SEL_W     = 3;
  localparam int CAND_N    = 1 << SEL_W;
  localparam int CFG_AW    = 3;
  localparam int CFG_DW    = TBL_DEPTH / 2;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_SPLIT  = 2'd1,
    MODE_MUX    = 2'd2,
    MODE_RSVD   = 2'd3
  } lut_mode_e;

  typedef enum logic [1:0] {
    OUT_F  = 2'd0,
    OUT_G  = 2'd1,
    OUT_QX = 2'd2,
    OUT_QY = 2'd3
  } out_sel_e;

  typedef struct packed {
    logic [TBL_DEPTH-1:0]           tbl;
    logic [HALF_AW-1:0][SEL_W-1:0]  fsel;
    logic [HALF_AW-1:0][SEL_W-1:0]  gsel;
    logic [SEL_W-1:0]               msel;
    lut_mode_e                      mode;
    out_sel_e                       xsel;
    out_sel_e                       ysel;
    logic                           dsel_x;
    logic                           dsel_y;
  } lut_cfg_t;
endpackage

// File: rtl/lutc_cfg_regs.sv
module lutc_cfg_regs
  import lutc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output lut_cfg_t          cfg_q
);
  lut_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) begin
      case (cfg_addr)
        3'd0: cfg_d.tbl[CFG_DW-1:0]         = cfg_data;
        3'd1: cfg_d.tbl[TBL_DEPTH-1:CFG_DW] = cfg_data;
        3'd2: begin
          for (int k = 0; k < HALF_AW; k++) cfg_d.fsel[k] = cfg_data[k*SEL_W +: SEL_W];
          cfg_d.msel = cfg_data[HALF_AW*SEL_W +: SEL_W];
        end
        3'd3: begin
          for (int k = 0; k < HALF_AW; k++) cfg_d.gsel[k] = cfg_data[k*SEL_W +: SEL_W];
        end
        3'd4: begin
          cfg_d.mode   = lut_mode_e'(cfg_data[1:0]);
          cfg_d.xsel   = out_sel_e'(cfg_data[3:2]);
          cfg_d.ysel   = out_sel_e'(cfg_data[5:4]);
          cfg_d.dsel_x = cfg_data[6];
          cfg_d.dsel_y = cfg_data[7];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R11
  unused_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_addr > 3'd4) |=> $stable(cfg_q));

  // R11
  no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en) |=> $stable(cfg_q));
endmodule

// File: rtl/lutc_var_sel.sv
module lutc_var_sel
  import lutc_pkg::*;
(
  input  logic [CAND_N-1:0]              cand,
  input  logic [HALF_AW-1:0][SEL_W-1:0]  fsel,
  input  logic [HALF_AW-1:0][SEL_W-1:0]  gsel,
  input  logic [SEL_W-1:0]               msel,
  output logic [HALF_AW-1:0]             f_addr,
  output logic [HALF_AW-1:0]             g_addr,
  output logic                           mvar
);
  for (genvar k = 0; k < HALF_AW; k++) begin : g_bit
    assign f_addr[k] = cand[fsel[k]];
    assign g_addr[k] = cand[gsel[k]];
  end
  assign mvar = cand[msel];
endmodule

// File: rtl/lutc_table.sv
module lutc_table
  import lutc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TBL_DEPTH-1:0] tbl,
  input  lut_mode_e            mode,
  input  logic [HALF_AW-1:0]   f_addr,
  input  logic [HALF_AW-1:0]   g_addr,
  input  logic                 mvar,
  output logic                 f,
  output logic                 g
);
  logic lo_f, hi_f, hi_g;

  assign lo_f = tbl[{1'b0, f_addr}];
  assign hi_f = tbl[{1'b1, f_addr}];
  assign hi_g = tbl[{1'b1, g_addr}];

  always_comb begin
    case (mode)
      MODE_SPLIT: begin
        f = lo_f;
        g = hi_g;
      end
      MODE_MUX: begin
        f = mvar ? hi_g : lo_f;
        g = f;
      end
      default: begin
        f = mvar ? hi_f : lo_f;
        g = f;
      end
    endcase
  end

  // R1
  single_fg_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SINGLE || mode == MODE_RSVD) |-> (f == g));

  // R4
  mux_fg_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MUX) |-> (f == g));
endmodule

// File: rtl/lutc_regs.sv
module lutc_regs
  import lutc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic ce,
  input  logic hold,
  input  logic f,
  input  logic g,
  input  logic dsel_x,
  input  logic dsel_y,
  output logic qx,
  output logic qy
);
  logic load;
  logic qx_d, qy_d;

  assign load = ce && !hold;

  always_comb begin
    qx_d = qx;
    qy_d = qy;
    if (load) begin
      qx_d = dsel_x ? g : f;
      qy_d = dsel_y ? g : f;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge rd) begin
    if (!rst_n) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else if (rd) begin
      qx <= 1'b0;
      qy <= 1'b0;
    end else begin
      qx <= qx_d;
      qy <= qy_d;
    end
  end

  // R8
  direct_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |-> (!qx && !qy));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || rd)
    (!ce || hold) |=> ($stable(qx) && $stable(qy)));

  // R7
  load_source_chk: assert property (@(posedge clk) disable iff (!rst_n || rd)
    (ce && !hold) |=> (qx == $past(dsel_x ? g : f)) && (qy == $past(dsel_y ? g : f)));
endmodule

// File: rtl/lut5_logic_cell.sv
module lut5_logic_cell
  import lutc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TBL_AW-1:0] lin,
  input  logic              rd,
  input  logic              ce,
  input  logic              cfg_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  output logic              x,
  output logic              y
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  lut_cfg_t               cfg;
  logic [CAND_N-1:0]      cand;
  logic [HALF_AW-1:0]     f_addr, g_addr;
  logic                   mvar, f, g, qx, qy;
  logic                   x_pick, y_pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  lutc_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_s_n), .cfg_en(cfg_en),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_q(cfg)
  );

  assign cand = {1'b0, qy, qx, lin};

  lutc_var_sel u_sel (
    .cand(cand), .fsel(cfg.fsel), .gsel(cfg.gsel), .msel(cfg.msel),
    .f_addr(f_addr), .g_addr(g_addr), .mvar(mvar)
  );

  lutc_table u_tbl (
    .clk(clk), .rst_n(rst_s_n), .tbl(cfg.tbl), .mode(cfg.mode),
    .f_addr(f_addr), .g_addr(g_addr), .mvar(mvar), .f(f), .g(g)
  );

  lutc_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .rd(rd), .ce(ce), .hold(cfg_en),
    .f(f), .g(g), .dsel_x(cfg.dsel_x), .dsel_y(cfg.dsel_y),
    .qx(qx), .qy(qy)
  );

  always_comb begin
    case (cfg.xsel)
      OUT_F:   x_pick = f;
      OUT_G:   x_pick = g;
      OUT_QX:  x_pick = qx;
      default: x_pick = qy;
    endcase
    case (cfg.ysel)
      OUT_F:   y_pick = f;
      OUT_G:   y_pick = g;
      OUT_QX:  y_pick = qx;
      default: y_pick = qy;
    endcase
  end

  assign x = cfg_en ? 1'b0 : x_pick;
  assign y = cfg_en ? 1'b0 : y_pick;

  // R9
  regs_frozen_in_setup_chk: assert property (@(posedge clk) disable iff (!rst_s_n || rd)
    cfg_en |=> ($stable(qx) && $stable(qy)));
endmodule

// File: tb/lut5_logic_cell_bench.sv
`timescale 1ns/1ps
module lut5_logic_cell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  lin = '0;
  logic        rd = 1'b0;
  logic        ce = 1'b0;
  logic        cfg_en = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        x, y;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // shadow of the setup the bench has written
  logic [31:0] s_tbl;
  logic [11:0] s_fs, s_gs;
  logic [2:0]  s_ms;
  logic [1:0]  s_mode, s_xs, s_ys;
  logic        s_dx, s_dy;

  always #4 clk = ~clk;

  lut5_logic_cell u_lut5_logic_cell (
    .clk(clk), .rst_n(rst_n), .lin(lin), .rd(rd), .ce(ce),
    .cfg_en(cfg_en), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .x(x), .y(y)
  );

  // mode(2) and lin(5) stimulus
  localparam logic [6:0] VEC [18] = '{
    {2'd0, 5'b00000}, {2'd0, 5'b10110}, {2'd0, 5'b01001}, {2'd0, 5'b11111},
    {2'd1, 5'b00011}, {2'd1, 5'b10100}, {2'd1, 5'b01110}, {2'd1, 5'b11001},
    {2'd2, 5'b00101}, {2'd2, 5'b10101}, {2'd2, 5'b01100}, {2'd2, 5'b11100},
    {2'd2, 5'b10010}, {2'd3, 5'b00110}, {2'd3, 5'b10111}, {2'd3, 5'b01000},
    {2'd1, 5'b11110}, {2'd0, 5'b00001}
  };

  function automatic logic [1:0] model_fg(input logic [4:0] l, input logic qx, input logic qy);
    logic [7:0] cand;
    logic [3:0] fa, ga;
    logic       mv, f, g;
    cand = {1'b0, qy, qx, l};
    for (int k = 0; k < 4; k++) begin
      fa[k] = cand[s_fs[k*3 +: 3]];
      ga[k] = cand[s_gs[k*3 +: 3]];
    end
    mv = cand[s_ms];
    case (s_mode)
      2'd1: begin f = s_tbl[{1'b0, fa}]; g = s_tbl[{1'b1, ga}]; end
      2'd2: begin f = mv ? s_tbl[{1'b1, ga}] : s_tbl[{1'b0, fa}]; g = f; end
      default: begin f = mv ? s_tbl[{1'b1, fa}] : s_tbl[{1'b0, fa}]; g = f; end
    endcase
    return {g, f};
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_en = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_en = 1'b0;
  endtask

  task automatic push_cfg();
    cfg_write(3'd0, s_tbl[15:0]);
    cfg_write(3'd1, s_tbl[31:16]);
    cfg_write(3'd2, {1'b0, s_ms, s_fs});
    cfg_write(3'd3, {4'b0, s_gs});
    cfg_write(3'd4, {8'h00, s_dy, s_dx, s_ys, s_xs, s_mode});
  endtask

  task automatic apply(input logic [4:0] l);
    @(negedge clk);
    lin = l;
    #2;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] fg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    apply(5'b11111);
    check("R10 x after reset", x, 1'b0);
    check("R10 y after reset", y, 1'b0);

    // R1 R3 R4 R6: vector walk, x=F, y=G
    s_tbl = 32'hA5C3_1E96;
    s_fs = {3'd3, 3'd2, 3'd1, 3'd0};
    s_gs = {3'd0, 3'd1, 3'd2, 3'd3};
    s_ms = 3'd4;
    s_mode = 2'd0; s_xs = 2'd0; s_ys = 2'd1; s_dx = 1'b0; s_dy = 1'b0;
    push_cfg();
    for (int i = 0; i < 18; i++) begin
      if (VEC[i][6:5] != s_mode) begin
        s_mode = VEC[i][6:5];
        cfg_write(3'd4, {8'h00, s_dy, s_dx, s_ys, s_xs, s_mode});
      end
      apply(VEC[i][4:0]);
      fg = model_fg(VEC[i][4:0], 1'b0, 1'b0);
      check(s_mode == 2'd1 ? "R3 split F on x" : (s_mode == 2'd2 ? "R4 mux F on x" : "R1 single F on x"), x, fg[0]);
      check(s_mode == 2'd1 ? "R3 split G on y" : (s_mode == 2'd2 ? "R4 mux G on y" : "R1 single G on y"), y, fg[1]);
    end

    // R2: five-input AND
    s_tbl = 32'h8000_0000; s_mode = 2'd0;
    push_cfg();
    for (int i = 0; i < 32; i++) begin
      apply(5'(i));
      check("R2 and5", x, (i == 31) ? 1'b1 : 1'b0);
    end

    // R10: reset clears a loaded setup
    apply(5'b11111);
    check("R10 before reset", x, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R10 table cleared", x, 1'b0);

    // R7: register load and hold, x=QX y=QY, F = A
    s_tbl = 32'h0000_0002;
    s_fs = {3'd7, 3'd7, 3'd7, 3'd0};
    s_gs = {3'd7, 3'd7, 3'd7, 3'd7};
    s_ms = 3'd7; s_mode = 2'd0; s_xs = 2'd2; s_ys = 2'd3; s_dx = 1'b0; s_dy = 1'b0;
    push_cfg();
    @(negedge clk); ce = 1'b1; lin = 5'b00001;
    @(negedge clk); #1;
    check("R7 qx loaded F", x, 1'b1);
    check("R7 qy loaded F", y, 1'b1);
    ce = 1'b0; lin = 5'b00000;
    @(negedge clk); #1;
    check("R7 qx held with ce low", x, 1'b1);
    check("R7 qy held with ce low", y, 1'b1);

    // R8: asynchronous clear, sampled before any clock edge
    @(negedge clk); rd = 1'b1; #1;
    check("R8 qx cleared async", x, 1'b0);
    check("R8 qy cleared async", y, 1'b0);
    @(negedge clk); rd = 1'b0;

    // R7: QY loads G in split mode (G = entry 16 = 1, F = A = 0)
    s_tbl = 32'h0001_0002; s_mode = 2'd1; s_dy = 1'b1;
    push_cfg();
    @(negedge clk); ce = 1'b1; lin = 5'b00000;
    @(negedge clk); ce = 1'b0; #1;
    check("R7 qx loaded F=0", x, 1'b0);
    check("R7 qy loaded G=1", y, 1'b1);

    // R5: feedback and constant select codes (qx=0, qy=1), x=F
    s_tbl = 32'h0000_0002; s_mode = 2'd0; s_xs = 2'd0; s_ys = 2'd1;
    s_fs = {3'd7, 3'd7, 3'd7, 3'd5};
    push_cfg();
    apply(5'b11111);
    check("R5 code 5 picks QX", x, 1'b0);
    s_fs = {3'd7, 3'd7, 3'd7, 3'd6};
    cfg_write(3'd2, {1'b0, s_ms, s_fs});
    apply(5'b00000);
    check("R5 code 6 picks QY", x, 1'b1);
    check("R6 y shows G", y, 1'b1);
    s_fs = {3'd7, 3'd7, 3'd7, 3'd7}; s_tbl = 32'h0000_0003;
    push_cfg();
    apply(5'b00000);
    check("R5 code 7 constant 0", x, 1'b1);
    s_tbl = 32'h0000_0002;
    cfg_write(3'd0, s_tbl[15:0]);
    apply(5'b11111);
    check("R5 code 7 ignores inputs", x, 1'b0);

    // R9: setup blocks outputs and freezes registers (F=1, qx=0, qy=1)
    s_tbl = 32'h0000_0003; s_xs = 2'd2; s_ys = 2'd3; s_dx = 1'b0; s_dy = 1'b0;
    push_cfg();
    @(negedge clk); ce = 1'b1; cfg_en = 1'b1; cfg_addr = 3'd5; cfg_data = 16'hFFFF;
    #2;
    check("R9 x low in setup", x, 1'b0);
    check("R9 y low in setup", y, 1'b0);
    @(negedge clk); cfg_en = 1'b0; ce = 1'b0; #2;
    check("R9 qx frozen", x, 1'b0);
    check("R9 qy frozen", y, 1'b1);

    // R11: unused addresses change nothing
    cfg_write(3'd6, 16'hFFFF);
    cfg_write(3'd7, 16'h0000);
    #2;
    check("R11 steering kept x", x, 1'b0);
    check("R11 steering kept y", y, 1'b1);
    s_xs = 2'd0;
    cfg_write(3'd4, {8'h00, s_dy, s_dx, s_ys, s_xs, s_mode});
    cfg_write(3'd5, 16'h0000);
    apply(5'b10101);
    check("R11 table kept", x, 1'b1);
    check("R6 x shows F", x, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule